// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block takes pixels from an image sensor that drives a parallel data bus together with a pixel clock, a line-valid sync and a frame-valid sync. All sensor pins are sampled in the system clock domain. The pixel clock is oversampled there, and one of its two edges is chosen as the sampling strike. Per frame, the block takes 8, 10, 12 or 14 data bits per pixel and packs them into 32-bit words. The words go into a small output FIFO. A DMA engine reads the words through a data register and is told to do so by a request level.

Software programs a control register. It sets the sampling edge, the inactive level of each sync pin, the pixel width and a frame decimation rate. It also chooses single-frame or continuous capture, and selects in-band sync codes in place of the two sync pins. Three sticky status flags report a finished frame, a lost word and a malformed sync code. Each flag has its own interrupt enable and can be cleared by writing one. Register offsets: 0 control, 1 interrupt enable, 2 status (read), 3 flag clear (write), 4 data (read, pops the FIFO). Flag bit order in enable, status and clear: bit 0 frame done, bit 1 overrun, bit 2 sync error.

Top module: `pcam_capture`

## Requirements
- R1: After reset the control, enable and status registers read 0, `dma_req` and `irq` are low, and a data read returns 0.
- R2: Control bits [7:6] select the pixel width: 00 = 8, 01 = 10, 10 = 12, 11 = 14 bits. In 8-bit mode four successive pixels fill one word with the first pixel in bits [7:0]. Data lines above bit 7 are ignored.
- R3: In 10/12/14-bit modes two pixels fill one word, the first in bits [15:0]. Each pixel is masked to its width and zero-extended to 16 bits.
- R4: Control bit 3 = 1 samples data on the rising pixel-clock edge; 0 samples on the falling edge.
- R5: Control bit 4 = 1 makes vsync high the invalid level (0: low). Control bit 5 does the same for hsync. A frame starts when vsync turns valid and ends when it turns invalid. Pixels are taken only while both syncs are valid.
- R6: Capture runs only while control bit 0 (enable) and bit 1 (capture) are both set. Otherwise no word is produced and no flag is raised.
- R7: With control bit 2 (snapshot) set, the end of the first captured frame sets the frame flag and clears the capture bit, so later frames are ignored.
- R8: With bit 2 clear, successive frames are captured and each one sets the frame flag.
- R9: Control bits [10:9] set the frame rate: 00 every frame, 01 every second, 10 every fourth, 11 every eighth frame, counting from the first frame after capture starts.
- R10: The output FIFO holds 4 words and `dma_req` is high while it holds any word. A completed word that finds the FIFO full is dropped and sets the overrun flag (status bit 1).
- R11: Writing 1 to a bit of the clear register clears only that status flag. `irq` is high while any flag is set with its enable bit set.
- R12: With control bit 8 set, the syncs come from the bytes FF 00 00 XY on data[7:0]: XY = C0 frame start, D0 frame end, 80 line start, 90 line end. Bytes outside a code and inside an open line are pixels.
- R13: In embedded mode a broken prefix or an XY value outside those four sets the sync-error flag (status bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk | input | 1 | Sensor pixel clock (oversampled) |
| cam_hsync | input | 1 | Line sync pin |
| cam_vsync | input | 1 | Frame sync pin |
| cam_data | input | DATA_W | Sensor pixel data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at offset 4) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| dma_req | output | 1 | Output FIFO holds at least one word |
| irq | output | 1 | Enabled flag pending |

## Verification
The state hardest to reach from the ports is a word being completed into a full FIFO. This only happens when the sensor side keeps producing while nothing drains. The bench sends a frame of six words with no reads, so that the last two words hit a full FIFO, and then checks that the first four stored words are intact. Wrong-edge sampling is made visible by changing the data pins between the two pixel-clock edges, so a design that strikes on the opposite edge captures the previous pixel. The frame-rate skipping is reached by sending three frames in a row under one configuration.

// File: rtl/pcam_pkg.sv
package pcam_pkg;

    localparam int CTRL_W  = 11;
    localparam int FLAG_W  = 3;
    localparam int WORD_W  = 32;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_IE   = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_CLR  = 3'd3;
    localparam logic [2:0] A_DATA = 3'd4;

    localparam logic [7:0] XY_FRAME_START = 8'hC0;
    localparam logic [7:0] XY_FRAME_END   = 8'hD0;
    localparam logic [7:0] XY_LINE_START  = 8'h80;
    localparam logic [7:0] XY_LINE_END    = 8'h90;

    typedef enum logic [1:0] {W8 = 2'd0, W10 = 2'd1, W12 = 2'd2, W14 = 2'd3} width_e;

    typedef enum logic [1:0] {EMB_IDLE, EMB_FF, EMB_Z1, EMB_Z2} emb_state_e;

    // control register layout, bit 0 = enable
    typedef struct packed {
        logic [1:0] rate;
        logic       embedded;
        width_e     width;
        logic       hs_inv_high;
        logic       vs_inv_high;
        logic       pclk_rise;
        logic       snapshot;
        logic       capture;
        logic       enable;
    } ctrl_t;

    // bit 0 frame, bit 1 overrun, bit 2 sync error
    typedef struct packed {
        logic err;
        logic ovr;
        logic frame;
    } flags_t;

    function automatic logic [15:0] pix_mask(width_e w);
        case (w)
            W8:      return 16'h00FF;
            W10:     return 16'h03FF;
            W12:     return 16'h0FFF;
            default: return 16'h3FFF;
        endcase
    endfunction

    function automatic logic [2:0] rate_mask(logic [1:0] r);
        case (r)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/pcam_sync.sv
module pcam_sync
    import pcam_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data,
    input  logic              hs,
    input  logic              vs,
    input  logic              hs_inv_high,
    input  logic              vs_inv_high,
    input  logic              embedded,
    output logic              pix_valid,
    output logic              frame_start,
    output logic              frame_end,
    output logic              code_err
);

    logic       vs_valid, hs_valid, vs_valid_q;
    logic [7:0] lo_byte;
    emb_state_e es, es_n;
    logic       fa, fa_n, la, la_n;
    logic       e_start, e_end, e_err, e_pix;
    logic       p_start, p_end, p_pix;

    assign vs_valid = vs ^ vs_inv_high;
    assign hs_valid = hs ^ hs_inv_high;
    assign lo_byte  = data[7:0];

    always_ff @(posedge clk) begin
        if (rst)         vs_valid_q <= 1'b0;
        else if (strobe) vs_valid_q <= vs_valid;
    end

    assign p_start = strobe && vs_valid && !vs_valid_q;
    assign p_end   = strobe && !vs_valid && vs_valid_q;
    assign p_pix   = strobe && vs_valid && hs_valid;

    always_comb begin
        es_n    = es;
        fa_n    = fa;
        la_n    = la;
        e_start = 1'b0;
        e_end   = 1'b0;
        e_err   = 1'b0;
        e_pix   = 1'b0;
        if (strobe && embedded) begin
            case (es)
                EMB_IDLE: begin
                    if (lo_byte == 8'hFF) es_n = EMB_FF;
                    else                  e_pix = fa && la;
                end
                EMB_FF: begin
                    if (lo_byte == 8'h00) es_n = EMB_Z1;
                    else begin e_err = 1'b1; es_n = EMB_IDLE; end
                end
                EMB_Z1: begin
                    if (lo_byte == 8'h00) es_n = EMB_Z2;
                    else begin e_err = 1'b1; es_n = EMB_IDLE; end
                end
                default: begin
                    es_n = EMB_IDLE;
                    case (lo_byte)
                        XY_FRAME_START: begin fa_n = 1'b1; la_n = 1'b0; e_start = 1'b1; end
                        XY_FRAME_END:   begin fa_n = 1'b0; la_n = 1'b0; e_end = 1'b1; end
                        XY_LINE_START:  la_n = fa;
                        XY_LINE_END:    la_n = 1'b0;
                        default:        e_err = 1'b1;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !embedded) begin
            es <= EMB_IDLE;
            fa <= 1'b0;
            la <= 1'b0;
        end else begin
            es <= es_n;
            fa <= fa_n;
            la <= la_n;
        end
    end

    assign pix_valid   = embedded ? e_pix   : p_pix;
    assign frame_start = embedded ? e_start : p_start;
    assign frame_end   = embedded ? e_end   : p_end;
    assign code_err    = e_err;

    p_err_needs_embedded_r13: assert property (@(posedge clk) disable iff (rst)
        code_err |-> (embedded && strobe));

endmodule

// File: rtl/pcam_pack.sv
module pcam_pack
    import pcam_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    input  width_e            width,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);

    localparam int LANES = WORD_W / 8;

    logic [1:0]  cnt, slot;
    logic        last;
    logic [15:0] pix16, m16;
    logic [7:0]  lane_q [LANES];

    assign pix16 = 16'(pix_data);
    assign m16   = pix16 & pix_mask(width);
    assign slot  = clear ? 2'd0 : cnt;
    assign last  = (width == W8) ? (slot == 2'd3) : (slot == 2'd1);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic       hit;
        logic [7:0] val;
        always_comb begin
            if (width == W8) begin
                hit = (slot == 2'(l));
                val = m16[7:0];
            end else begin
                hit = (slot[0] == (l >= 2));
                val = (l % 2 == 0) ? m16[7:0] : m16[15:8];
            end
        end
        always_ff @(posedge clk) begin
            if (rst)                   lane_q[l] <= 8'h00;
            else if (pix_valid && hit) lane_q[l] <= val;
        end
        assign word[l*8 +: 8] = lane_q[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= 2'd0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= pix_valid && last;
            if (pix_valid)  cnt <= last ? 2'd0 : slot + 2'd1;
            else if (clear) cnt <= 2'd0;
        end
    end

    p_word_needs_pixel_r2: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(pix_valid));

endmodule

// File: rtl/pcam_fifo.sv
module pcam_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    // DEPTH is a power of two so the pointers wrap naturally
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count;

    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));
    p_nonempty_after_push_r10: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> !empty);

endmodule

// File: rtl/pcam_capture.sv
module pcam_capture
    import pcam_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cam_pclk,
    input  logic              cam_hsync,
    input  logic              cam_vsync,
    input  logic [DATA_W-1:0] cam_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dma_req,
    output logic              irq
);

    ctrl_t  ctrl;
    flags_t ie, st, st_set, st_clr;

    logic              pclk_q, pclk_q2, hs_q, vs_q;
    logic [DATA_W-1:0] data_q;
    logic              strobe, run;
    logic              pix_valid, frame_start, frame_end, code_err;
    logic              take, in_frame, frame_done, accept, pack_clear;
    logic [2:0]        fcnt;
    logic              word_valid, fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [WORD_W-1:0] word, fifo_dout;

    // input sampling and pixel-clock edge strike
    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q  <= 1'b0;
            pclk_q2 <= 1'b0;
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            data_q  <= '0;
        end else begin
            pclk_q  <= cam_pclk;
            pclk_q2 <= pclk_q;
            hs_q    <= cam_hsync;
            vs_q    <= cam_vsync;
            data_q  <= cam_data;
        end
    end

    assign strobe = ctrl.pclk_rise ? (pclk_q && !pclk_q2) : (!pclk_q && pclk_q2);
    assign run    = ctrl.enable && ctrl.capture;

    pcam_sync #(.DATA_W(DATA_W)) sync_i (
        .clk         (clk),
        .rst         (rst),
        .strobe      (strobe),
        .data        (data_q),
        .hs          (hs_q),
        .vs          (vs_q),
        .hs_inv_high (ctrl.hs_inv_high),
        .vs_inv_high (ctrl.vs_inv_high),
        .embedded    (ctrl.embedded),
        .pix_valid   (pix_valid),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .code_err    (code_err)
    );

    // frame tracking and decimation
    assign take       = (fcnt & rate_mask(ctrl.rate)) == 3'd0;
    assign frame_done = run && in_frame && frame_end && !frame_start;
    assign accept     = pix_valid && run && (frame_start ? take : in_frame);
    assign pack_clear = frame_start && run && take;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            fcnt     <= 3'd0;
            in_frame <= 1'b0;
        end else if (frame_start) begin
            fcnt     <= fcnt + 3'd1;
            in_frame <= take;
        end else if (frame_end) begin
            in_frame <= 1'b0;
        end
    end

    pcam_pack #(.DATA_W(DATA_W)) pack_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (pack_clear),
        .pix_valid  (accept),
        .pix_data   (data_q),
        .width      (ctrl.width),
        .word_valid (word_valid),
        .word       (word)
    );

    assign fifo_push = word_valid && !fifo_full;
    assign fifo_pop  = reg_rd && (reg_addr == A_DATA) && !fifo_empty;

    pcam_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (word),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ie   <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) ctrl <= ctrl_t'(reg_wdata);
            if (reg_wr && reg_addr == A_IE)   ie   <= flags_t'(reg_wdata[FLAG_W-1:0]);
            if (frame_done && ctrl.snapshot)  ctrl.capture <= 1'b0;
        end
    end

    assign st_set = '{err: code_err && run, ovr: word_valid && fifo_full, frame: frame_done};
    assign st_clr = (reg_wr && reg_addr == A_CLR) ? flags_t'(reg_wdata[FLAG_W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= (st & ~st_clr) | st_set;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = 32'(ctrl);
            A_IE:    reg_rdata = 32'(ie);
            A_STAT:  reg_rdata = 32'(st);
            A_DATA:  reg_rdata = fifo_empty ? 32'h0 : fifo_dout;
            default: reg_rdata = 32'h0;
        endcase
    end

    assign dma_req = !fifo_empty;
    assign irq     = |(st & ie);

    p_ovr_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(st.ovr) |-> $past(fifo_full));
    p_snap_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ctrl.snapshot) |=> !ctrl.capture);
    p_frame_flag_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(st.frame) |-> $past(in_frame));

endmodule

// File: tb/pcam_capture_tb_top.sv
module pcam_capture_tb_top;

    localparam int DW = 14;
    localparam logic [2:0] A_CTRL = 3'd0, A_IE = 3'd1, A_STAT = 3'd2, A_CLR = 3'd3, A_DATA = 3'd4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cam_pclk = 1'b0, cam_hsync = 1'b0, cam_vsync = 1'b0;
    logic [DW-1:0] cam_data = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [10:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          dma_req, irq;

    pcam_capture #(.DATA_W(DW), .FIFO_DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .cam_pclk(cam_pclk), .cam_hsync(cam_hsync),
        .cam_vsync(cam_vsync), .cam_data(cam_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_req(dma_req), .irq(irq)
    );

    always #5 clk = ~clk;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    bit  cur_rise, cur_vs_inv, cur_hs_inv;
    logic [DW-1:0] px[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [10:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // one pixel period; data changes between the two clock edges
    task automatic cam_step(input logic [DW-1:0] d, input bit h, input bit v);
        @(negedge clk); cam_pclk = cur_rise ? 1'b0 : 1'b1;
        repeat (2) @(negedge clk);
        cam_data = d; cam_hsync = h; cam_vsync = v;
        repeat (2) @(negedge clk);
        cam_pclk = cur_rise ? 1'b1 : 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [10:0] mk_cfg(input logic [1:0] rate, input bit emb, input logic [1:0] w,
                                           input bit hs_inv, input bit vs_inv, input bit rise,
                                           input bit snap, input bit cap, input bit en);
        return {rate, emb, w, hs_inv, vs_inv, rise, snap, cap, en};
    endfunction

    task automatic configure(input logic [10:0] cfg);
        cur_rise   = cfg[3];
        cur_vs_inv = cfg[4];
        cur_hs_inv = cfg[5];
        reg_write(A_CTRL, cfg & 11'h7FC);
        cam_step('0, cur_hs_inv, cur_vs_inv);
        cam_step('0, cur_hs_inv, cur_vs_inv);
        reg_write(A_CTRL, cfg);
    endtask

    task automatic send_pin_frame(input int lines, input int ppl);
        px.delete();
        cam_step('0, cur_hs_inv, cur_vs_inv);
        cam_step('0, cur_hs_inv, !cur_vs_inv);
        for (int ln = 0; ln < lines; ln++) begin
            for (int p = 0; p < ppl; p++) begin
                logic [DW-1:0] d;
                d = DW'($urandom);
                px.push_back(d);
                cam_step(d, !cur_hs_inv, !cur_vs_inv);
            end
            cam_step('0, cur_hs_inv, !cur_vs_inv);
        end
        cam_step('0, cur_hs_inv, cur_vs_inv);
        cam_step('0, cur_hs_inv, cur_vs_inv);
    endtask

    task automatic emb_code(input logic [7:0] xy);
        cam_step({6'($urandom), 8'hFF}, 1'b0, 1'b0);
        cam_step({6'($urandom), 8'h00}, 1'b0, 1'b0);
        cam_step({6'($urandom), 8'h00}, 1'b0, 1'b0);
        cam_step({6'($urandom), xy}, 1'b0, 1'b0);
    endtask

    task automatic send_emb_frame(input int lines, input int ppl);
        px.delete();
        emb_code(8'hC0);
        for (int ln = 0; ln < lines; ln++) begin
            emb_code(8'h80);
            for (int p = 0; p < ppl; p++) begin
                logic [DW-1:0] d;
                d = {6'($urandom), 8'(1 + ($urandom % 254))};
                px.push_back(d);
                cam_step(d, 1'b0, 1'b0);
            end
            emb_code(8'h90);
        end
        emb_code(8'hD0);
        cam_step(14'h0010, 1'b0, 1'b0);
    endtask

    function automatic logic [31:0] exp_word(input int k, input int wc);
        logic [15:0] m, lo, hi;
        if (wc == 0)
            return {px[4*k+3][7:0], px[4*k+2][7:0], px[4*k+1][7:0], px[4*k][7:0]};
        m  = (wc == 1) ? 16'h03FF : (wc == 2) ? 16'h0FFF : 16'h3FFF;
        lo = 16'(px[2*k]) & m;
        hi = 16'(px[2*k+1]) & m;
        return {hi, lo};
    endfunction

    task automatic drain(input string tag, input int nw, input int wc);
        logic [31:0] v;
        for (int k = 0; k < nw; k++) begin
            chk({tag, " R10 req"}, 32'(dma_req), 32'd1);
            reg_read(A_DATA, v);
            chk(tag, v, exp_word(k, wc));
        end
        chk({tag, " R10 empty"}, 32'(dma_req), 32'd0);
    endtask

    task automatic expect_flags(input string tag, input logic [2:0] f);
        logic [31:0] v;
        reg_read(A_STAT, v);
        chk(tag, v, 32'(f));
        reg_write(A_CLR, 11'h7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1234_5678));
        cur_rise = 1'b1; cur_vs_inv = 1'b0; cur_hs_inv = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        reg_read(A_IE, v);   chk("R1 ie", v, 32'h0);
        reg_read(A_STAT, v); chk("R1 status", v, 32'h0);
        reg_read(A_DATA, v); chk("R1 data", v, 32'h0);
        chk("R1 dma_req", 32'(dma_req), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);

        // R2 R3 R4 R5 R8: all widths, both edges, random sync polarities
        for (int i = 0; i < 8; i++) begin
            int  wc;
            bit  vsi, hsi;
            wc  = i % 4;
            vsi = 1'($urandom);
            hsi = 1'($urandom);
            configure(mk_cfg(2'd0, 1'b0, 2'(wc), hsi, vsi, i >= 4, 1'b0, 1'b1, 1'b1));
            send_pin_frame(2, (wc == 0) ? 8 : 4);
            drain((wc == 0) ? "R2 R4 R5 word" : "R3 R4 R5 word", 4, wc);
            expect_flags("R8 frame flag", 3'b001);
        end

        // R8 two successive frames under one configuration
        configure(mk_cfg(2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
        send_pin_frame(2, 4);
        drain("R8 first frame", 4, 2);
        send_pin_frame(1, 8);
        drain("R8 second frame", 4, 2);
        expect_flags("R8 flag", 3'b001);

        // R6 capture gating
        configure(mk_cfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
        send_pin_frame(2, 8);
        chk("R6 no word without capture", 32'(dma_req), 32'd0);
        expect_flags("R6 no flag without capture", 3'b000);
        configure(mk_cfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
        send_pin_frame(2, 8);
        chk("R6 no word without enable", 32'(dma_req), 32'd0);
        expect_flags("R6 no flag without enable", 3'b000);

        // R7 snapshot
        configure(mk_cfg(2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
        send_pin_frame(2, 8);
        drain("R7 snapshot words", 4, 0);
        reg_read(A_CTRL, v);
        chk("R7 capture bit cleared", v & 32'h2, 32'h0);
        expect_flags("R7 frame flag", 3'b001);
        send_pin_frame(2, 8);
        chk("R7 later frame ignored", 32'(dma_req), 32'd0);
        expect_flags("R7 no second flag", 3'b000);

        // R9 every second frame
        configure(mk_cfg(2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        send_pin_frame(2, 8);
        drain("R9 frame 1 taken", 4, 0);
        expect_flags("R9 flag frame 1", 3'b001);
        send_pin_frame(2, 8);
        chk("R9 frame 2 skipped", 32'(dma_req), 32'd0);
        expect_flags("R9 no flag frame 2", 3'b000);
        send_pin_frame(2, 8);
        drain("R9 frame 3 taken", 4, 0);
        expect_flags("R9 flag frame 3", 3'b001);

        // R10 overrun: six words into a four-entry FIFO
        configure(mk_cfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        send_pin_frame(3, 8);
        drain("R10 kept words", 4, 0);
        expect_flags("R10 overrun flag", 3'b011);

        // R11 interrupt enable and selective clear
        reg_write(A_IE, 11'h1);
        send_pin_frame(2, 8);
        drain("R11 words", 4, 0);
        chk("R11 irq set", 32'(irq), 32'd1);
        reg_write(A_CLR, 11'h6);
        reg_read(A_STAT, v);
        chk("R11 other clear bits ignored", v, 32'h1);
        chk("R11 irq still set", 32'(irq), 32'd1);
        reg_write(A_CLR, 11'h1);
        reg_read(A_STAT, v);
        chk("R11 flag cleared", v, 32'h0);
        chk("R11 irq low", 32'(irq), 32'd0);

        // R12 embedded sync codes
        configure(mk_cfg(2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        send_emb_frame(2, 8);
        drain("R12 embedded words", 4, 0);
        expect_flags("R12 frame flag", 3'b001);

        // R13 malformed code
        reg_write(A_IE, 11'h4);
        emb_code(8'h55);
        cam_step(14'h0010, 1'b0, 1'b0);
        chk("R13 irq on error", 32'(irq), 32'd1);
        expect_flags("R13 error flag", 3'b100);
        cam_step({6'd0, 8'hFF}, 1'b0, 1'b0);
        cam_step({6'd0, 8'h12}, 1'b0, 1'b0);
        expect_flags("R13 broken prefix", 3'b100);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule